// File: doc/BRIEF.md
# Cascadable Trigger-Controlled Timer Pair

Two 8-bit up-counters that each advance on one of eight prescaled tick enables. Each counter counts from zero up to its own period value. On the tick where the count equals the period, the counter returns to zero, raises a one-cycle interrupt and flips a toggle output. In one-shot mode the counter then stays at zero until it is started again. A counter is started and stopped either by a software run level or by an external trigger pin. The trigger pin passes through a two-flop synchroniser and a stability filter before the counter sees it.

A third source setting turns the trigger into a pulse-width meter. An accepted rising edge clears the count, the counter runs while the pulse stays high, and the accepted falling edge copies the count into a capture register and sets a done flag. Setting the cascade input joins the two counters into one 16-bit counter. Channel 0 holds the low byte and channel 1 the high byte, and channel 1's controls govern the joined timer.

The tick enables come from a prescaler outside this block. There is no data stream here, so every pin is a plain level or pulse.

Top module: `trig_timer_pair`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, every count, capture, capture-done, interrupt and toggle output is zero.
- R2: A channel advances by one only in cycles where tick_i[clksel] is high; clksel is the bit index into tick_i. In every other cycle its count holds.
- R3: Auto-reload: on an advancing tick with count equal to period, the count becomes 0, irq_o is high for exactly the following cycle, and tog_o inverts. Otherwise the count increments, so one cycle spans period+1 ticks.
- R4: One-shot (oneshot_i=1): after the matching tick the count stays 0. It starts again only after run_i has been low (software source) or on the next accepted rising trigger edge (trigger sources).
- R5: Source encoding per channel: src=00 software, counting while run_i is high; src=01 gated, counting while the filtered trigger is high; src=10 or 11 pulse-width measurement. The trigger has no effect under src=00, and run_i has no effect under the trigger sources.
- R6: A trigger level is accepted only after it has been sampled on three consecutive clock edges. A level first sampled at edge k becomes the filtered level at edge k+4. A pulse lasting two clocks or less is ignored.
- R7: Pulse-width mode: an accepted rising edge clears the count and cap_done_o. The count advances on ticks while the filtered trigger is high. The accepted falling edge copies the count into cap_o, sets cap_done_o, and the count then holds.
- R8: Cascade (cascade_i=1): channel 1's count increments when channel 0 advances from FF to 00. The 16-bit value is matched against {period_i[1],period_i[0]}. The joined timer uses channel 1's src, run, trigger, one-shot, interrupt and toggle and channel 0's clksel. irq_o[0] stays 0, and channel 0's toggle and capture-done hold.
- R9: Cascade pulse-width: the falling edge captures the 16-bit count, high byte in cap_o[1] and low byte in cap_o[0], and sets cap_done_o[1].
- R10: Gated mode does not clear the count: when the filtered trigger drops, counting pauses, and it resumes from the held value on the next accepted high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 8 | Prescaled tick enables, one per clock choice |
| cascade_i | input | 1 | Join both channels into one 16-bit timer |
| run_i | input | 2 | Software run level per channel |
| oneshot_i | input | 2 | One-shot mode per channel |
| src_i | input | 2x2 | Start/stop source per channel (00 software, 01 gated, 1x pulse width) |
| clksel_i | input | 2x3 | Tick index per channel |
| period_i | input | 2x8 | Period value per channel |
| trig_i | input | 2 | Asynchronous trigger per channel |
| count_o | output | 2x8 | Current count per channel |
| cap_o | output | 2x8 | Captured pulse width per channel |
| cap_done_o | output | 2 | Capture-done flag per channel |
| irq_o | output | 2 | One-cycle match interrupt per channel |
| tog_o | output | 2 | Output that inverts on every match |

## Verification
The hardest cases to reach from the ports are the exact boundary of the trigger filter and a 16-bit capture larger than one byte.

For the filter, the bench changes trig_i on falling edges and holds it for exactly one, two and three clocks. The accepted pulses and the ignored ones therefore differ by a single sample.

For the 16-bit capture, the bench holds the trigger high for several hundred cycles with every-cycle ticks, so that the low byte carries into the high byte before the falling edge. It toggles channel 0's own trigger during that run to show that those inputs are ignored. A behavioural model, driven by the same inputs, is compared with every output on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    SRC_SW     = 2'b00,
    SRC_GATE   = 2'b01,
    SRC_PW     = 2'b10,
    SRC_PW_ALT = 2'b11
  } src_e;
endpackage

// File: rtl/tmr_trig_filter.sv
module tmr_trig_filter #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int FW = $clog2(FILT + 1);

  logic          s1, s2;
  logic [FW-1:0] fcnt;
  logic          upd;

  // level differs and has been steady long enough
  assign upd    = (s2 != lvl_o) && (fcnt == FW'(FILT - 1));
  assign rise_o = upd & s2;
  assign fall_o = upd & ~s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      lvl_o <= 1'b0;
      fcnt  <= '0;
    end else begin
      s1 <= trig_i;
      s2 <= s1;
      if (s2 == lvl_o) begin
        fcnt <= '0;
      end else if (upd) begin
        lvl_o <= s2;
        fcnt  <= '0;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  generate
    if (FILT == 3) begin : g_chk
      // a new filtered level was present on the three previous synchronised samples
      assert_filter_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lvl_o) || $fell(lvl_o)) |->
          ($past(s2) == lvl_o && $past(s2, 2) == lvl_o && $past(s2, 3) == lvl_o));
    end
  endgenerate
endmodule

// File: rtl/tmr_count_slice.sv
module tmr_count_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  input  logic         cap_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cap_o,
  output logic         at_period_o,
  output logic         at_max_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
      cap_o <= '0;
    end else begin
      if (clr_i)      cnt_o <= '0;
      else if (inc_i) cnt_o <= cnt_o + 1'b1;
      if (cap_i)      cap_o <= cnt_o;
    end
  end

  assign at_period_o = (cnt_o == period_i);
  assign at_max_o    = &cnt_o;

  // count moves only when steered by the controller
  assert_slice_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr_i) && !$past(inc_i)) |-> $stable(cnt_o));
endmodule

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  src_e src_i,
  input  logic run_i,
  input  logic oneshot_i,
  input  logic tick_i,
  input  logic match_i,
  input  logic trig_lvl_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic step_o,
  output logic restart_o,
  output logic capture_o,
  output logic irq_o,
  output logic tog_o,
  output logic cap_done_o
);
  logic trig_src, pw, active, wrap, os_q, os_clr;

  assign trig_src  = (src_i != SRC_SW);
  assign pw        = (src_i == SRC_PW) || (src_i == SRC_PW_ALT);
  assign active    = trig_src ? (trig_lvl_i & ~fall_i) : run_i;
  assign step_o    = en_i & active & ~os_q & tick_i;
  assign wrap      = step_o & match_i;
  assign restart_o = wrap | (en_i & pw & rise_i);
  assign capture_o = en_i & pw & fall_i;
  assign os_clr    = trig_src ? rise_i : ~run_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      os_q       <= 1'b0;
      irq_o      <= 1'b0;
      tog_o      <= 1'b0;
      cap_done_o <= 1'b0;
    end else begin
      if (wrap && oneshot_i) os_q <= 1'b1;
      else if (os_clr)       os_q <= 1'b0;
      irq_o <= wrap;
      if (wrap) tog_o <= ~tog_o;
      if (capture_o)               cap_done_o <= 1'b1;
      else if (en_i && pw && rise_i) cap_done_o <= 1'b0;
    end
  end

  assert_cap_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |=> cap_done_o);
endmodule

// File: rtl/trig_timer_pair.sv
module trig_timer_pair
  import tmr_pkg::*;
#(
  parameter int W        = 8,
  parameter int NTICK    = 8,
  parameter int FILT     = 3,
  localparam int SELW    = $clog2(NTICK)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NTICK-1:0]          tick_i,
  input  logic                      cascade_i,
  input  logic [NCH-1:0]            run_i,
  input  logic [NCH-1:0]            oneshot_i,
  input  logic [NCH-1:0][1:0]       src_i,
  input  logic [NCH-1:0][SELW-1:0]  clksel_i,
  input  logic [NCH-1:0][W-1:0]     period_i,
  input  logic [NCH-1:0]            trig_i,
  output logic [NCH-1:0][W-1:0]     count_o,
  output logic [NCH-1:0][W-1:0]     cap_o,
  output logic [NCH-1:0]            cap_done_o,
  output logic [NCH-1:0]            irq_o,
  output logic [NCH-1:0]            tog_o
);
  logic [NCH-1:0] lvl, rise, fall;
  logic [NCH-1:0] en_c, tick_c, match_c;
  logic [NCH-1:0] step, restart, capture, irq_q;
  logic [NCH-1:0] inc_s, clr_s, cap_s, at_per, at_max;

  // steering between separate and joined operation
  always_comb begin
    en_c[0]    = ~cascade_i;
    en_c[1]    = 1'b1;
    tick_c[0]  = tick_i[clksel_i[0]];
    tick_c[1]  = cascade_i ? tick_i[clksel_i[0]] : tick_i[clksel_i[1]];
    match_c[0] = at_per[0];
    match_c[1] = cascade_i ? (at_per[0] & at_per[1]) : at_per[1];
    inc_s[0]   = cascade_i ? step[1]    : step[0];
    clr_s[0]   = cascade_i ? restart[1] : restart[0];
    cap_s[0]   = cascade_i ? capture[1] : capture[0];
    inc_s[1]   = cascade_i ? (step[1] & at_max[0]) : step[1];
    clr_s[1]   = restart[1];
    cap_s[1]   = capture[1];
  end

  assign irq_o = {irq_q[1], irq_q[0] & ~cascade_i};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_trig_filter #(.FILT(FILT)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (trig_i[c]),
      .lvl_o  (lvl[c]),
      .rise_o (rise[c]),
      .fall_o (fall[c])
    );

    tmr_chan_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_c[c]),
      .src_i      (src_e'(src_i[c])),
      .run_i      (run_i[c]),
      .oneshot_i  (oneshot_i[c]),
      .tick_i     (tick_c[c]),
      .match_i    (match_c[c]),
      .trig_lvl_i (lvl[c]),
      .rise_i     (rise[c]),
      .fall_i     (fall[c]),
      .step_o     (step[c]),
      .restart_o  (restart[c]),
      .capture_o  (capture[c]),
      .irq_o      (irq_q[c]),
      .tog_o      (tog_o[c]),
      .cap_done_o (cap_done_o[c])
    );

    tmr_count_slice #(.W(W)) u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .inc_i       (inc_s[c]),
      .clr_i       (clr_s[c]),
      .cap_i       (cap_s[c]),
      .period_i    (period_i[c]),
      .cnt_o       (count_o[c]),
      .cap_o       (cap_o[c]),
      .at_period_o (at_per[c]),
      .at_max_o    (at_max[c])
    );

    assert_irq_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> (count_o[c] == '0));

    assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[c] && $past(oneshot_i[c]) && !cascade_i && $past(!cascade_i))
        |=> (count_o[c] == '0));

    assert_capture_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_done_o[c]) |-> (cap_o[c] == $past(count_o[c])));
  end

  // high byte only moves on a low-byte carry while joined
  assert_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_i && $past(cascade_i) && (count_o[1] != $past(count_o[1])) && (count_o[1] != '0))
      |-> (($past(count_o[0]) == {W{1'b1}}) && (count_o[0] == '0)));
endmodule

// File: tb/tb_trig_timer_pair.sv
module tb_trig_timer_pair;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      tick = '0;
  logic            cascade = 1'b0;
  logic [1:0]      run = '0;
  logic [1:0]      oneshot = '0;
  logic [1:0][1:0] src = '0;
  logic [1:0][2:0] clksel = '0;
  logic [1:0][7:0] period = '0;
  logic [1:0]      trig = '0;
  logic [1:0][7:0] count, cap;
  logic [1:0]      cap_done, irq, tog;

  trig_timer_pair dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cascade_i(cascade), .run_i(run),
    .oneshot_i(oneshot), .src_i(src), .clksel_i(clksel), .period_i(period),
    .trig_i(trig), .count_o(count), .cap_o(cap), .cap_done_o(cap_done),
    .irq_o(irq), .tog_o(tog)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0, tcnt = 0;
  bit done = 0;
  int m_cnt[2], m_cap[2], m_cd[2], m_irq[2], m_tog[2], m_os[2];
  int m_s1[2], m_s2[2], m_lvl[2], m_fc[2];

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_cnt[c] = 0; m_cap[c] = 0; m_cd[c] = 0; m_irq[c] = 0; m_tog[c] = 0; m_os[c] = 0;
      m_s1[c] = 0; m_s2[c] = 0; m_lvl[c] = 0; m_fc[c] = 0;
    end
  endtask

  task automatic model_step();
    int rise[2], fall[2], ocnt[2];
    int v, per, sel, modv, nv, trg, pw, active, stp, wrap;
    for (int c = 0; c < 2; c++) begin
      int upd;
      ocnt[c] = m_cnt[c];
      upd = (m_s2[c] != m_lvl[c]) && (m_fc[c] == 2);
      rise[c] = upd && m_s2[c] == 1;
      fall[c] = upd && m_s2[c] == 0;
    end
    for (int c = 0; c < 2; c++) begin
      trg = (src[c] != 2'b00);
      pw  = src[c][1];
      if (cascade && c == 0) begin
        if (trg ? rise[0] : !run[0]) m_os[0] = 0;
        m_irq[0] = 0;
        continue;
      end
      if (cascade) begin
        v = ocnt[1] * 256 + ocnt[0]; per = period[1] * 256 + period[0];
        sel = clksel[0]; modv = 65536;
      end else begin
        v = ocnt[c]; per = period[c]; sel = clksel[c]; modv = 256;
      end
      active = trg ? (m_lvl[c] && !fall[c]) : run[c];
      stp  = active && !m_os[c] && tick[sel];
      wrap = stp && (v == per);
      if (wrap || (pw && rise[c])) nv = 0;
      else if (stp) nv = (v + 1) % modv;
      else nv = v;
      if (pw && fall[c]) begin
        m_cd[c] = 1;
        if (cascade) begin m_cap[0] = v % 256; m_cap[1] = v / 256; end
        else m_cap[c] = v;
      end else if (pw && rise[c]) m_cd[c] = 0;
      if (wrap && oneshot[c]) m_os[c] = 1;
      else if (trg ? rise[c] : !run[c]) m_os[c] = 0;
      m_irq[c] = wrap;
      if (wrap) m_tog[c] ^= 1;
      if (cascade) begin m_cnt[0] = nv % 256; m_cnt[1] = nv / 256; end
      else m_cnt[c] = nv;
    end
    for (int c = 0; c < 2; c++) begin
      if (m_s2[c] == m_lvl[c]) m_fc[c] = 0;
      else if (m_fc[c] == 2) begin m_lvl[c] = m_s2[c]; m_fc[c] = 0; end
      else m_fc[c]++;
      m_s2[c] = m_s1[c];
      m_s1[c] = trig[c];
    end
  endtask

  task automatic chk(string tag, string nm, int c, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s ch%0d act=%0d exp=%0d t=%0t", tag, nm, c, act, exp, $time);
    end
  endtask

  task automatic compare_all(string tag);
    for (int c = 0; c < 2; c++) begin
      chk(tag, "count", c, count[c], m_cnt[c]);
      chk(tag, "cap", c, cap[c], m_cap[c]);
      chk(tag, "cap_done", c, cap_done[c], m_cd[c]);
      chk(tag, "irq", c, irq[c], m_irq[c]);
      chk(tag, "tog", c, tog[c], m_tog[c]);
    end
  endtask

  task automatic cyc(string tag);
    tcnt++;
    for (int k = 0; k < 8; k++) tick[k] = ((tcnt % (k + 1)) == 0);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic run_n(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic pulse(int c, int hi, int lo, string tag);
    trig[c] = 1'b1; run_n(hi, tag);
    trig[c] = 1'b0; run_n(lo, tag);
  endtask

  // R1: outputs zero in reset and right after
  task automatic do_reset();
    rst_n = 1'b0; tick = '0; model_reset();
    repeat (3) @(negedge clk);
    compare_all("R1");
    cascade = 0; run = 0; oneshot = 0; src = '0; clksel = '0; period = '0; trig = '0;
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R2 R3 with R5: software source, two different tick rates, trigger ignored
    run = 2'b11; clksel[0] = 3'd0; period[0] = 8'd5; clksel[1] = 3'd3; period[1] = 8'd2;
    for (int i = 0; i < 150; i++) begin
      trig[0] = (i % 7) < 3; trig[1] = (i % 5) < 4;
      cyc("R2,R3,R5");
    end
    trig = '0; run[0] = 1'b0; run_n(20, "R5");

    // R4: software one-shot, restart after run low; gated one-shot on ch1
    do_reset();
    oneshot = 2'b11; run[0] = 1'b1; clksel[0] = 3'd1; period[0] = 8'd4;
    src[1] = 2'b01; clksel[1] = 3'd0; period[1] = 8'd6;
    trig[1] = 1'b1; run_n(40, "R4");
    run[0] = 1'b0; trig[1] = 1'b0; run_n(10, "R4");
    run[0] = 1'b1; trig[1] = 1'b1; run_n(40, "R4");

    // R6 R10: gated mode, filter boundary, pause and resume
    do_reset();
    src[0] = 2'b01; clksel[0] = 3'd0; period[0] = 8'd200;
    pulse(0, 10, 8, "R6,R10");
    pulse(0, 2, 8, "R6");
    pulse(0, 3, 8, "R6");
    pulse(0, 1, 10, "R6");
    pulse(0, 12, 10, "R10");

    // R7: pulse width on both channels
    do_reset();
    src[1] = 2'b10; clksel[1] = 3'd0; period[1] = 8'd255;
    src[0] = 2'b11; clksel[0] = 3'd2; period[0] = 8'd255;
    pulse(1, 12, 10, "R7");
    pulse(1, 3, 10, "R7");
    pulse(1, 2, 10, "R7");
    pulse(1, 40, 10, "R7");
    pulse(0, 20, 10, "R7");

    // R8: joined software count, ch0 controls and ch1 clksel ignored
    do_reset();
    cascade = 1'b1; run = 2'b10; oneshot[0] = 1'b1; src[0] = 2'b10;
    clksel[0] = 3'd0; clksel[1] = 3'd7; period[1] = 8'h01; period[0] = 8'h05;
    for (int i = 0; i < 700; i++) begin
      trig[0] = (i % 9) < 5;
      cyc("R8");
    end
    oneshot[1] = 1'b1; run_n(400, "R4,R8");

    // R9: joined pulse-width capture wider than one byte
    do_reset();
    cascade = 1'b1; src[1] = 2'b10; src[0] = 2'b10; clksel[0] = 3'd0;
    period[1] = 8'hFF; period[0] = 8'hFF;
    trig[1] = 1'b1;
    for (int i = 0; i < 300; i++) begin
      trig[0] = (i % 11) < 6;
      cyc("R9");
    end
    trig = '0; run_n(20, "R9");
    pulse(1, 5, 10, "R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule